// File: doc/BRIEF.md
# Supply-Driven Power Mode Controller

This block owns the operating mode of a low-power radio system-on-chip. It watches two digital supply flags (supply above the turn-on level, supply at or below the lower turn-off level), a hardware reset pin, a software reset command, wake pins, several timer time-outs and sleep requests from the CPU. It moves the chip among six modes, which are coded by increasing energy demand: OFF, Deep Sleep, Flywheel Sleep, ShortTerm Sleep, Standby and CPU. The supply flags form a hysteresis band. Inside that band the current mode is held.

Any event that restarts the chip produces a one-cycle supply-on reset pulse. After that pulse the CPU runs on the internal RC clock, the radio configuration is invalid, the radio engines are stopped, and a one-hot cause register records the event. The wake paths keep different amounts of state. A Standby wake keeps everything. A ShortTerm wake loses only the radio configuration. Wakes from Deep Sleep and Flywheel Sleep restart the chip completely. The block also switches the CPU clock to the crystal, gates the transmit and receive engines, drives the power-domain enables, and drives a tri-state pin that reports the turn-on comparator. If the mode register ever holds an undefined code, the next cycle forces a supply-on reset, and cause bit 6 records it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, `mode` is 0 (OFF). In the same state `sor`, `rst_cause`, `clk_xtal`, `radio_cfg_valid`, `tx_en`, `rx_en` and `ind_oe` are 0.
- R2: `mode` uses these codes: OFF=0, Deep=1, Flywheel=2, ShortTerm=3, Standby=4, CPU=5. In OFF, `sup_above_on` moves the block to CPU on the next cycle with a supply-on reset.
- R3: In any mode other than OFF, `sup_at_off` moves the block to OFF on the next cycle. It has priority over every other event and gives no `sor`. When neither supply flag is set, the mode is held.
- R4: A supply-on reset starts on `rst_pin` or `wdt_tmo` in any mode other than OFF. It also starts on `fly_tmo` in any mode other than OFF or Deep, and on `sw_rst` in CPU mode. On the next cycle `sor` is 1 for one cycle, `mode` is 5, and `clk_xtal`, `radio_cfg_valid`, `tx_en` and `rx_en` are 0.
- R5: `rst_cause` is one-hot and is replaced on each supply-on reset. The bits are: supply=bit0, pin=bit1, software=bit2, watchdog=bit3, flywheel=bit4, wake=bit5. When several causes occur together, the order is pin > watchdog > flywheel > software > wake. `cause_clr` in CPU mode clears the register unless a reset occurs in the same cycle. Otherwise the register holds.
- R6: In CPU mode, `sleep_req` with `sleep_dst` in 1..4 enters that mode on the next cycle. Any other `sleep_dst` value is ignored.
- R7: In Standby, `cpu_tmr_wake` or `ext_irq` returns to CPU with no `sor`. The clock selection, the radio configuration and any running engine are kept.
- R8: Entering Deep, Flywheel or ShortTerm clears `clk_xtal`, `radio_cfg_valid` and the engines. In ShortTerm, `st_tmo` returns to CPU on the RC clock with no `sor`, and `rst_cause` is unchanged.
- R9: A set bit of `wake_pin` in Deep or Flywheel gives a supply-on reset with the wake cause. In Deep, `fly_tmo`, `st_tmo`, `cpu_tmr_wake` and `ext_irq` are ignored.
- R10: In CPU mode, `clk_xtal` is updated each cycle to `xtal_req` AND `xtal_stable`. In Standby it holds.
- R11: In CPU mode, `tx_req` or `rx_req` starts its engine on the next cycle, but only when `clk_xtal`, `xtal_stable` and `radio_cfg_valid` are 1 and no engine is running. Transmit wins if both are requested. `engine_done` stops the engines in any mode. `cpu_abort` stops them in CPU mode only.
- R12: `radio_cfg_set` in CPU mode sets `radio_cfg_valid`.
- R13: `ind_oe` is 0 from reset until `sup_above_on` has been seen, and 1 from then on. While it is 1, `ind_o` is `sup_above_on` delayed by one cycle.
- R14: The power-domain outputs depend only on the mode. `cpu_run` is 1 in CPU. `core_pwr_en` is 1 in ShortTerm, Standby and CPU. `radio_pwr_en` is 1 in Standby and CPU. `fly_en` is 1 in Flywheel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| sup_above_on | input | 1 | Supply is above the turn-on threshold |
| sup_at_off | input | 1 | Supply is at or below the turn-off threshold |
| rst_pin | input | 1 | Hardware reset pin, active high |
| sw_rst | input | 1 | Software reset command |
| wdt_tmo | input | 1 | Watchdog time-out |
| fly_tmo | input | 1 | Flywheel timer time-out |
| st_tmo | input | 1 | Short-term timer time-out |
| cpu_tmr_wake | input | 1 | CPU timer wake |
| ext_irq | input | 1 | External interrupt |
| wake_pin | input | NWAKE | Wake pins |
| sleep_req | input | 1 | CPU sleep request |
| sleep_dst | input | 3 | Requested sleep mode code |
| xtal_req | input | 1 | CPU requests the crystal clock |
| xtal_stable | input | 1 | Crystal oscillator is stable |
| radio_cfg_set | input | 1 | Software finished the radio configuration |
| tx_req | input | 1 | Start the transmit engine |
| rx_req | input | 1 | Start the receive engine |
| cpu_abort | input | 1 | CPU aborts the running engine |
| engine_done | input | 1 | Engine finished |
| cause_clr | input | 1 | Clear the reset-cause register |
| mode | output | 3 | Current mode code |
| sor | output | 1 | Supply-on reset pulse |
| clk_xtal | output | 1 | CPU clocked from the crystal (0 = RC) |
| radio_cfg_valid | output | 1 | Radio configuration is valid |
| tx_en | output | 1 | Transmit engine running |
| rx_en | output | 1 | Receive engine running |
| rst_cause | output | 7 | One-hot cause of the last supply-on reset |
| cpu_run | output | 1 | CPU clock enable |
| core_pwr_en | output | 1 | Digital core domain enable |
| radio_pwr_en | output | 1 | Radio and crystal domain enable |
| fly_en | output | 1 | Flywheel timer enable |
| ind_o | output | 1 | Threshold indicator value |
| ind_oe | output | 1 | Threshold indicator output enable |

## Verification
A directed walk visits every mode and every exit from it. Simultaneous events separate the shutdown priority and the reset-cause priority from a plain first-come order. Sleep codes outside 1..4, an abort during Standby, and timer events in Deep Sleep show whether ignored stimulus really leaves the mode, the engines and the cause unchanged. A long seeded random run then mixes drifting supply levels, rare reset pulses and dense event traffic. Every output is compared each cycle with a bench model, which exposes wrong state retention across the different wake paths.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int NWAKE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sup_above_on,
  input  logic             sup_at_off,
  input  logic             rst_pin,
  input  logic             sw_rst,
  input  logic             wdt_tmo,
  input  logic             fly_tmo,
  input  logic             st_tmo,
  input  logic             cpu_tmr_wake,
  input  logic             ext_irq,
  input  logic [NWAKE-1:0] wake_pin,
  input  logic             sleep_req,
  input  logic [2:0]       sleep_dst,
  input  logic             xtal_req,
  input  logic             xtal_stable,
  input  logic             radio_cfg_set,
  input  logic             tx_req,
  input  logic             rx_req,
  input  logic             cpu_abort,
  input  logic             engine_done,
  input  logic             cause_clr,
  output logic [2:0]       mode,
  output logic             sor,
  output logic             clk_xtal,
  output logic             radio_cfg_valid,
  output logic             tx_en,
  output logic             rx_en,
  output logic [6:0]       rst_cause,
  output logic             cpu_run,
  output logic             core_pwr_en,
  output logic             radio_pwr_en,
  output logic             fly_en,
  output logic             ind_o,
  output logic             ind_oe
);
  localparam logic [2:0] M_OFF = 3'd0, M_DEEP = 3'd1, M_FLY = 3'd2,
                         M_SHORT = 3'd3, M_STBY = 3'd4, M_CPU = 3'd5;

  logic [2:0] mode_q, mode_n;
  logic       clk_q, clk_n, cfg_q, cfg_n, tx_q, tx_n, rx_q, rx_n;
  logic [6:0] cause_q, cause_n, cause_sel;
  logic       sor_q, seen_q, ind_q;

  wire in_off   = mode_q == M_OFF;
  wire in_deep  = mode_q == M_DEEP;
  wire in_fly   = mode_q == M_FLY;
  wire in_short = mode_q == M_SHORT;
  wire in_stby  = mode_q == M_STBY;
  wire in_cpu   = mode_q == M_CPU;

  wire shut   = !in_off && sup_at_off;
  wire s_sup  = in_off && sup_above_on;
  wire s_ill  = mode_q > M_CPU;
  wire s_pin  = !in_off && rst_pin;
  wire s_wdt  = !in_off && wdt_tmo;
  wire s_fly  = !in_off && !in_deep && fly_tmo;
  wire s_sw   = in_cpu && sw_rst;
  wire s_wake = (in_deep || in_fly) && |wake_pin;
  wire sor_ev = !shut && (s_sup || s_ill || s_pin || s_wdt || s_fly || s_sw || s_wake);

  wire go_sleep  = in_cpu && sleep_req && sleep_dst >= M_DEEP && sleep_dst <= M_STBY;
  wire drop_rad  = shut || sor_ev || (go_sleep && sleep_dst <= M_SHORT);
  wire eng_stop  = drop_rad || engine_done || (in_cpu && cpu_abort);
  wire eng_ok    = in_cpu && clk_q && xtal_stable && cfg_q && !tx_q && !rx_q;

  always_comb begin
    if      (s_sup)  cause_sel = 7'b0000001;
    else if (s_ill)  cause_sel = 7'b1000000;
    else if (s_pin)  cause_sel = 7'b0000010;
    else if (s_wdt)  cause_sel = 7'b0001000;
    else if (s_fly)  cause_sel = 7'b0010000;
    else if (s_sw)   cause_sel = 7'b0000100;
    else             cause_sel = 7'b0100000;
  end

  always_comb begin
    mode_n = mode_q;
    if (shut)                                      mode_n = M_OFF;
    else if (sor_ev)                               mode_n = M_CPU;
    else if (go_sleep)                             mode_n = sleep_dst;
    else if (in_stby && (cpu_tmr_wake || ext_irq)) mode_n = M_CPU;
    else if (in_short && st_tmo)                   mode_n = M_CPU;
  end

  assign clk_n   = drop_rad ? 1'b0 : in_cpu ? (xtal_req && xtal_stable) : clk_q;
  assign cfg_n   = drop_rad ? 1'b0 : (in_cpu && radio_cfg_set) ? 1'b1 : cfg_q;
  assign tx_n    = eng_stop ? 1'b0 : tx_q || (eng_ok && tx_req);
  assign rx_n    = eng_stop ? 1'b0 : rx_q || (eng_ok && rx_req && !tx_req);
  assign cause_n = sor_ev ? cause_sel : (in_cpu && cause_clr) ? '0 : cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_OFF;
      clk_q   <= 1'b0;
      cfg_q   <= 1'b0;
      tx_q    <= 1'b0;
      rx_q    <= 1'b0;
      cause_q <= '0;
      sor_q   <= 1'b0;
      seen_q  <= 1'b0;
      ind_q   <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      clk_q   <= clk_n;
      cfg_q   <= cfg_n;
      tx_q    <= tx_n;
      rx_q    <= rx_n;
      cause_q <= cause_n;
      sor_q   <= sor_ev;
      seen_q  <= seen_q || sup_above_on;
      ind_q   <= sup_above_on;
    end
  end

  assign mode            = mode_q;
  assign sor             = sor_q;
  assign clk_xtal        = clk_q;
  assign radio_cfg_valid = cfg_q;
  assign tx_en           = tx_q;
  assign rx_en           = rx_q;
  assign rst_cause       = cause_q;
  assign cpu_run         = in_cpu;
  assign core_pwr_en     = in_short || in_stby || in_cpu;
  assign radio_pwr_en    = in_stby || in_cpu;
  assign fly_en          = in_fly;
  assign ind_o           = ind_q;
  assign ind_oe          = seen_q;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sup_at_off,
  input logic [2:0] mode,
  input logic       sor,
  input logic       clk_xtal,
  input logic       radio_cfg_valid,
  input logic       tx_en,
  input logic       rx_en,
  input logic [6:0] rst_cause,
  input logic       ind_oe
);
  // R2
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n) mode <= 3'd5);
  // R3
  shutdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sup_at_off && mode != 3'd0) |=> (mode == 3'd0 && !sor));
  // R4
  sor_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sor |-> (mode == 3'd5 && !clk_xtal && !radio_cfg_valid && !tx_en && !rx_en));
  // R5
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sor |-> $countones(rst_cause) == 1);
  // R11
  engine_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({tx_en, rx_en}));
  // R11
  tx_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> ($past(clk_xtal) && $past(radio_cfg_valid) && $past(mode) == 3'd5));
  // R13
  ind_keep_chk: assert property (@(posedge clk) disable iff (!rst_n) ind_oe |=> ind_oe);
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_at_off(sup_at_off), .mode(mode), .sor(sor),
  .clk_xtal(clk_xtal), .radio_cfg_valid(radio_cfg_valid), .tx_en(tx_en),
  .rx_en(rx_en), .rst_cause(rst_cause), .ind_oe(ind_oe)
);

// File: tb/test_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module test_pwr_mode_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic above = 0, at_off = 0, rst_pin = 0, sw_rst = 0, wdt = 0, fly = 0, st = 0;
  logic tmr = 0, irq = 0, sleep_req = 0, xreq = 0, xst = 0, cfg_set = 0;
  logic txr = 0, rxr = 0, abort_i = 0, done = 0, clr = 0;
  logic [1:0] wake = 0;
  logic [2:0] dst = 0;
  logic [2:0] mode;
  logic sor, clk_xtal, cfg_v, tx_en, rx_en, cpu_run, core_en, rad_en, fly_en, ind_o, ind_oe;
  logic [6:0] cause;

  logic [2:0] m_mode;
  logic m_clk, m_cfg, m_tx, m_rx, m_sor, m_seen, m_ind;
  logic [6:0] m_cause;
  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pwr_mode_ctrl #(.NWAKE(2)) i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .sup_above_on(above), .sup_at_off(at_off),
    .rst_pin(rst_pin), .sw_rst(sw_rst), .wdt_tmo(wdt), .fly_tmo(fly), .st_tmo(st),
    .cpu_tmr_wake(tmr), .ext_irq(irq), .wake_pin(wake), .sleep_req(sleep_req),
    .sleep_dst(dst), .xtal_req(xreq), .xtal_stable(xst), .radio_cfg_set(cfg_set),
    .tx_req(txr), .rx_req(rxr), .cpu_abort(abort_i), .engine_done(done),
    .cause_clr(clr), .mode(mode), .sor(sor), .clk_xtal(clk_xtal),
    .radio_cfg_valid(cfg_v), .tx_en(tx_en), .rx_en(rx_en), .rst_cause(cause),
    .cpu_run(cpu_run), .core_pwr_en(core_en), .radio_pwr_en(rad_en),
    .fly_en(fly_en), .ind_o(ind_o), .ind_oe(ind_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic shut, s_sup, s_pin, s_wdt, s_fly, s_sw, s_wake, ev, go, drop, stop, ok;
    logic [6:0] sel;
    logic [2:0] nm;
    if (!rst_n) begin
      m_mode = 0; m_clk = 0; m_cfg = 0; m_tx = 0; m_rx = 0; m_cause = 0;
      m_sor = 0; m_seen = 0; m_ind = 0;
      return;
    end
    shut   = m_mode != 0 && at_off;
    s_sup  = m_mode == 0 && above;
    s_pin  = m_mode != 0 && rst_pin;
    s_wdt  = m_mode != 0 && wdt;
    s_fly  = m_mode != 0 && m_mode != 1 && fly;
    s_sw   = m_mode == 5 && sw_rst;
    s_wake = (m_mode == 1 || m_mode == 2) && wake != 0;
    ev     = !shut && (s_sup || s_pin || s_wdt || s_fly || s_sw || s_wake);
    sel = s_sup ? 7'h01 : s_pin ? 7'h02 : s_wdt ? 7'h08 : s_fly ? 7'h10 : s_sw ? 7'h04 : 7'h20;
    go   = m_mode == 5 && sleep_req && dst >= 1 && dst <= 4;
    drop = shut || ev || (go && dst <= 3);
    nm = shut ? 3'd0 : ev ? 3'd5 : go ? dst :
         (m_mode == 4 && (tmr || irq)) ? 3'd5 : (m_mode == 3 && st) ? 3'd5 : m_mode;
    stop = drop || done || (m_mode == 5 && abort_i);
    ok   = m_mode == 5 && m_clk && xst && m_cfg && !m_tx && !m_rx;
    m_tx    = stop ? 1'b0 : (m_tx || (ok && txr));
    m_rx    = stop ? 1'b0 : (m_rx || (ok && rxr && !txr));
    m_cause = ev ? sel : (m_mode == 5 && clr) ? 7'h00 : m_cause;
    m_clk   = drop ? 1'b0 : (m_mode == 5) ? (xreq && xst) : m_clk;
    m_cfg   = drop ? 1'b0 : (m_mode == 5 && cfg_set) ? 1'b1 : m_cfg;
    m_mode  = nm;
    m_sor   = ev;
    m_seen  = m_seen || above;
    m_ind   = above;
  endtask

  task automatic compare_all();
    chk("R2 mode", mode, m_mode);
    chk("R4 sor", sor, m_sor);
    chk("R10 clk_xtal", clk_xtal, m_clk);
    chk("R12 radio_cfg_valid", cfg_v, m_cfg);
    chk("R11 tx_en", tx_en, m_tx);
    chk("R11 rx_en", rx_en, m_rx);
    chk("R5 rst_cause", cause, m_cause);
    chk("R14 cpu_run", cpu_run, m_mode == 5);
    chk("R14 core_pwr_en", core_en, m_mode >= 3 && m_mode <= 5);
    chk("R14 radio_pwr_en", rad_en, m_mode == 4 || m_mode == 5);
    chk("R14 fly_en", fly_en, m_mode == 2);
    chk("R13 ind_oe", ind_oe, m_seen);
    chk("R13 ind_o", ind_o, m_ind);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic clr_ev();
    rst_pin = 0; sw_rst = 0; wdt = 0; fly = 0; st = 0; tmr = 0; irq = 0; wake = 0;
    sleep_req = 0; dst = 0; cfg_set = 0; txr = 0; rxr = 0; abort_i = 0; done = 0; clr = 0;
  endtask

  task automatic sleep_to(input logic [2:0] d);
    sleep_req = 1; dst = d; cyc(); clr_ev();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    cyc(); cyc();
    // R1 reset state
    chk("R1 mode", mode, 0); chk("R1 sor", sor, 0); chk("R1 cause", cause, 0);
    chk("R1 ind_oe", ind_oe, 0); chk("R1 tx_en", tx_en, 0);
    rst_n = 1;
    cyc(); cyc();
    chk("R3 hold in OFF", mode, 0);
    above = 1; cyc();
    chk("R2 power-up to CPU", mode, 5); chk("R4 sor pulse", sor, 1);
    chk("R5 supply cause", cause, 7'h01); chk("R13 ind driven", ind_oe, 1);
    cyc();
    chk("R4 sor one cycle", sor, 0);
    sleep_to(3'd6);
    chk("R6 illegal sleep code ignored", mode, 5);
    sleep_to(3'd0);
    chk("R6 code 0 ignored", mode, 5);
    cfg_set = 1; xreq = 1; xst = 1; cyc(); clr_ev();
    chk("R10 crystal selected", clk_xtal, 1); chk("R12 cfg valid", cfg_v, 1);
    txr = 1; rxr = 1; cyc(); clr_ev();
    chk("R11 tx wins", tx_en, 1); chk("R11 rx held off", rx_en, 0);
    sleep_to(3'd4);
    chk("R6 enter standby", mode, 4);
    abort_i = 1; cyc(); clr_ev();
    chk("R11 abort ignored in standby", tx_en, 1);
    irq = 1; cyc(); clr_ev();
    chk("R7 wake to CPU", mode, 5); chk("R7 no sor", sor, 0);
    chk("R7 engine kept", tx_en, 1); chk("R7 clock kept", clk_xtal, 1);
    done = 1; cyc(); clr_ev();
    chk("R11 engine done", tx_en, 0);
    sleep_to(3'd3);
    chk("R8 short entry drops cfg", cfg_v, 0); chk("R8 short entry drops xtal", clk_xtal, 0);
    st = 1; cyc(); clr_ev();
    chk("R8 short wake", mode, 5); chk("R8 no sor", sor, 0);
    chk("R8 cause kept", cause, 7'h01); chk("R8 RC clock", clk_xtal, 0);
    sleep_to(3'd1);
    fly = 1; st = 1; tmr = 1; irq = 1; cyc(); clr_ev();
    chk("R9 deep ignores timers", mode, 1);
    wake = 2'b10; cyc(); clr_ev();
    chk("R9 wake sor", sor, 1); chk("R9 wake cause", cause, 7'h20);
    clr = 1; cyc(); clr_ev();
    chk("R5 cause cleared", cause, 0);
    sleep_to(3'd2);
    chk("R14 fly domain", fly_en, 1);
    fly = 1; cyc(); clr_ev();
    chk("R9 flywheel timeout cause", cause, 7'h10);
    rst_pin = 1; wdt = 1; sw_rst = 1; cyc(); clr_ev();
    chk("R4 pin beats watchdog", cause, 7'h02);
    sw_rst = 1; cyc(); clr_ev();
    chk("R4 software reset", cause, 7'h04);
    above = 0; cyc(); cyc();
    chk("R3 hold between thresholds", mode, 5);
    chk("R13 ind low", ind_o, 0); chk("R13 still driven", ind_oe, 1);
    at_off = 1; rst_pin = 1; cyc(); clr_ev();
    chk("R3 shutdown priority", mode, 0); chk("R3 no sor", sor, 0);
    chk("R14 core off", core_en, 0);
    at_off = 0; cyc();
    chk("R3 OFF held", mode, 0);
    above = 1; cyc();
    chk("R2 re-power", mode, 5);

    for (int i = 0; i < 6000; i++) begin
      int sup_st;
      clr_ev();
      sup_st = above ? 2 : at_off ? 0 : 1;
      if ($urandom % 100 < 2) sup_st = $urandom % 3;
      above = sup_st == 2; at_off = sup_st == 0;
      if ($urandom % 1000 < 2) rst_n = 0; else rst_n = 1;
      rst_pin = $urandom % 100 < 1; sw_rst = $urandom % 100 < 1;
      wdt = $urandom % 100 < 1; fly = $urandom % 100 < 2; st = $urandom % 100 < 6;
      tmr = $urandom % 100 < 4; irq = $urandom % 100 < 4;
      wake = ($urandom % 100 < 5) ? 2'($urandom) : 2'b00;
      sleep_req = $urandom % 100 < 8; dst = 3'($urandom);
      if ($urandom % 100 < 5) xreq = ~xreq;
      if ($urandom % 100 < 5) xst = ~xst;
      cfg_set = $urandom % 100 < 10; txr = $urandom % 100 < 10; rxr = $urandom % 100 < 10;
      abort_i = $urandom % 100 < 3; done = $urandom % 100 < 4; clr = $urandom % 100 < 5;
      cyc();
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule